// File: doc/BRIEF.md
# Shared-Logic Frequency Governor

This block decides the clock ratio requested for the logic that all cores share: the on-die ring, the last-level cache slices and the inter-socket link agents. Each core runs at its own ratio, and the shared logic scales apart from them. On every evaluation tick the governor looks at the ratios of the cores that are awake and picks a target. It then moves its registered request toward that target and raises a one-cycle strobe whenever the request changes.

Two inputs pin the request at the programmed top ratio. One is the maximum mode. The other is a scaling lock (override), which turns off all scaling. In dynamic mode the target follows the fastest core that is not in its enhanced-halt idle state. When every core is idle, the target falls to a programmable floor. A bias input chooses how a lower target is reached. Under the performance bias the request drops straight to the target. Under the power bias it drops by one ratio step per tick. A rise in the target is always taken at once.

Top module: `uncore_freq_gov`

## Requirements
- R1: While `rst_n` is low, `req_ratio` is 0 and `req_change` is 0.
- R2: In dynamic mode (`mode_max`=0, `scale_lock`=0), a tick with a target above the current request sets `req_ratio` to the target on the clock edge that samples the tick, under either bias.
- R3: With `mode_max`=1, a tick sets `req_ratio` to `max_ratio`, whatever the core ratios, halt flags and bias.
- R4: With `scale_lock`=1, a tick sets `req_ratio` to `max_ratio` even in dynamic mode with every core halted. With `scale_lock`=0 (the reset value driven by the system), scaling is allowed.
- R5: A core whose bit in `core_halt` is 1 is left out of the fastest-core search. When all bits are 1, the dynamic target is `min_ratio`.
- R6: With `bias_perf`=0 (power bias) in dynamic mode, a tick whose target is below the request lowers `req_ratio` by exactly 1.
- R7: With `bias_perf`=1 (performance bias), a tick whose target is below the request sets `req_ratio` to the target directly.
- R8: `req_ratio` changes only on a clock edge that samples `eval_tick`=1.
- R9: `req_change` is 1 for exactly the one cycle after an edge on which `req_ratio` took a new value, and 0 otherwise, including after a tick that leaves the value unchanged.
- R10: The dynamic target is limited to the range `min_ratio`..`max_ratio`: an active core above `max_ratio` gives `max_ratio`, and active cores all below `min_ratio` give `min_ratio` (`min_ratio` <= `max_ratio` is assumed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_tick | input | 1 | One-cycle evaluation pulse |
| core_ratio | input | NUM_CORES*6 | Per-core ratios, core k in bits [6k+5:6k] |
| core_halt | input | NUM_CORES | 1 = core k is in enhanced-halt idle |
| mode_max | input | 1 | 1 = maximum mode, 0 = dynamic mode |
| scale_lock | input | 1 | 1 = scaling suppressed, pinned at top |
| bias_perf | input | 1 | 1 = performance bias, 0 = power bias |
| min_ratio | input | 6 | Floor ratio used when all cores are idle |
| max_ratio | input | 6 | Top ratio |
| req_ratio | output | 6 | Registered requested shared-logic ratio |
| req_change | output | 1 | One-cycle strobe on a new request value |

## Verification
The hardest case to reach is the gradual descent under the power bias. It needs a high request already held, then a target that falls well below it, then several ticks in a row, with the bias held low the whole time. The stimulus first raises the request by waking a fast core, then halts every core, and checks each tick's single step down. It also checks that a rise taken in the middle of a descent still happens at once, and that a tick which repeats the current value leaves the strobe low.

// File: rtl/ufg_pkg.sv
package ufg_pkg;

  localparam int RATIO_W = 6;

  typedef logic [RATIO_W-1:0] ratio_t;

  // Limit a ratio to the closed range lo..hi (hi wins if lo > hi).
  function automatic ratio_t ufg_clamp(input ratio_t v, input ratio_t lo, input ratio_t hi);
    ratio_t r;
    r = (v < lo) ? lo : v;
    r = (r > hi) ? hi : r;
    return r;
  endfunction

  // Next request: rise at once, fall at once when jumping, else one step.
  function automatic ratio_t ufg_next(input ratio_t cur, input ratio_t tgt, input logic jump);
    if (tgt >= cur || jump) return tgt;
    return cur - ratio_t'(1);
  endfunction

endpackage

// File: rtl/ufg_fastest.sv
module ufg_fastest
  import ufg_pkg::*;
#(
  parameter int NUM_CORES = 8
) (
  input  logic [NUM_CORES*RATIO_W-1:0] ratios,
  input  logic [NUM_CORES-1:0]         halted,
  output ratio_t                       fastest,
  output logic                         any_active
);

  ratio_t masked [NUM_CORES];

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_mask
    assign masked[g] = halted[g] ? '0 : ratios[g*RATIO_W +: RATIO_W];
  end

  always_comb begin
    fastest = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      if (masked[k] > fastest) fastest = masked[k];
    end
  end

  assign any_active = |(~halted);

endmodule

// File: rtl/ufg_target.sv
module ufg_target
  import ufg_pkg::*;
(
  input  ratio_t fastest,
  input  logic   any_active,
  input  logic   mode_max,
  input  logic   scale_lock,
  input  ratio_t min_ratio,
  input  ratio_t max_ratio,
  output ratio_t target,
  output logic   pinned
);

  ratio_t dyn_pick;

  assign pinned   = mode_max | scale_lock;
  assign dyn_pick = any_active ? fastest : min_ratio;

  always_comb begin
    if (pinned) target = max_ratio;
    else        target = ufg_clamp(dyn_pick, min_ratio, max_ratio);
  end

endmodule

// File: rtl/ufg_stepper.sv
module ufg_stepper
  import ufg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  ratio_t target,
  input  logic   jump,
  output ratio_t ratio_q,
  output logic   change_q
);

  ratio_t ratio_d;
  logic   differs;

  assign ratio_d = ufg_next(ratio_q, target, jump);
  assign differs = tick && (ratio_d != ratio_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_q  <= '0;
      change_q <= 1'b0;
    end else begin
      if (tick) ratio_q <= ratio_d;
      change_q <= differs;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ratio_q)); // R8

  AST_STROBE_MEANS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    change_q |-> (ratio_q != $past(ratio_q))); // R9

  AST_NEW_MEANS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q != $past(ratio_q)) |-> change_q); // R9

  AST_ONE_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !jump && target < ratio_q) |=> ratio_q == $past(ratio_q) - ratio_t'(1)); // R6

  AST_RISE_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && target > ratio_q) |=> ratio_q == $past(target)); // R2

endmodule

// File: rtl/uncore_freq_gov.sv
module uncore_freq_gov
  import ufg_pkg::*;
#(
  parameter int NUM_CORES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         eval_tick,
  input  logic [NUM_CORES*RATIO_W-1:0] core_ratio,
  input  logic [NUM_CORES-1:0]         core_halt,
  input  logic                         mode_max,
  input  logic                         scale_lock,
  input  logic                         bias_perf,
  input  logic [RATIO_W-1:0]           min_ratio,
  input  logic [RATIO_W-1:0]           max_ratio,
  output logic [RATIO_W-1:0]           req_ratio,
  output logic                         req_change
);

  ratio_t fastest;
  ratio_t target;
  logic   any_active;
  logic   pinned;
  logic   jump;

  ufg_fastest #(.NUM_CORES(NUM_CORES)) i_fastest (
    .ratios     (core_ratio),
    .halted     (core_halt),
    .fastest    (fastest),
    .any_active (any_active)
  );

  ufg_target i_target (
    .fastest    (fastest),
    .any_active (any_active),
    .mode_max   (mode_max),
    .scale_lock (scale_lock),
    .min_ratio  (min_ratio),
    .max_ratio  (max_ratio),
    .target     (target),
    .pinned     (pinned)
  );

  assign jump = bias_perf | pinned;

  ufg_stepper i_stepper (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (eval_tick),
    .target   (target),
    .jump     (jump),
    .ratio_q  (req_ratio),
    .change_q (req_change)
  );

  AST_PINNED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_tick && pinned) |=> req_ratio == $past(max_ratio)); // R3

  AST_IDLE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_tick && !pinned && bias_perf && !any_active) |=> req_ratio == $past(min_ratio)); // R5

  AST_WITHIN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_tick && bias_perf) |=> req_ratio <= $past(max_ratio)); // R10

endmodule

// File: tb/test_uncore_freq_gov.sv
module test_uncore_freq_gov;
  localparam int NC = 8;
  localparam int W  = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            eval_tick = 1'b0;
  logic [NC*W-1:0] core_ratio = '0;
  logic [NC-1:0]   core_halt = '0;
  logic            mode_max = 1'b0;
  logic            scale_lock = 1'b0;
  logic            bias_perf = 1'b1;
  logic [W-1:0]    min_ratio = 6'd8;
  logic [W-1:0]    max_ratio = 6'd40;
  logic [W-1:0]    req_ratio;
  logic            req_change;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uncore_freq_gov #(.NUM_CORES(NC)) i_uncore_freq_gov (
    .clk(clk), .rst_n(rst_n), .eval_tick(eval_tick),
    .core_ratio(core_ratio), .core_halt(core_halt),
    .mode_max(mode_max), .scale_lock(scale_lock), .bias_perf(bias_perf),
    .min_ratio(min_ratio), .max_ratio(max_ratio),
    .req_ratio(req_ratio), .req_change(req_change)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_core(input int k, input int r);
    core_ratio[k*W +: W] = W'(r);
  endtask

  // Pulse the tick for one edge; return after the edge, at a falling edge.
  task automatic tick();
    @(negedge clk) eval_tick = 1'b1;
    @(negedge clk) eval_tick = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ratio", int'(req_ratio), 0);
    check("R1 strobe", int'(req_change), 0);
  endtask

  task automatic t_dynamic_rise();
    for (int k = 0; k < NC; k++) set_core(k, 10 + k);
    set_core(2, 35);
    core_halt = '0;
    bias_perf = 1'b1;
    tick();
    check("R2 fastest", int'(req_ratio), 35);
    check("R9 strobe on new", int'(req_change), 1);
    @(negedge clk);
    check("R9 strobe one cycle", int'(req_change), 0);
  endtask

  task automatic t_exclude_halted();
    core_halt = 8'b0000_0100;
    tick();
    check("R5/R7 halted excluded", int'(req_ratio), 17);
    tick();
    check("R9 no strobe same value", int'(req_change), 0);
    check("R9 value kept", int'(req_ratio), 17);
    core_halt = '1;
    tick();
    check("R5 all idle floor", int'(req_ratio), 8);
  endtask

  task automatic t_power_descent();
    bias_perf = 1'b0;
    core_halt = 8'b1111_1101;
    set_core(1, 22);
    tick();
    check("R2 rise under power bias", int'(req_ratio), 22);
    core_halt = '1;
    tick();
    check("R6 step 1", int'(req_ratio), 21);
    check("R9 strobe on step", int'(req_change), 1);
    tick();
    check("R6 step 2", int'(req_ratio), 20);
    core_halt = 8'b1111_1101;
    set_core(1, 30);
    tick();
    check("R6 rise mid descent", int'(req_ratio), 30);
  endtask

  task automatic t_no_tick();
    core_halt = '1;
    bias_perf = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 held without tick", int'(req_ratio), 30);
    check("R8 no strobe", int'(req_change), 0);
  endtask

  task automatic t_max_mode();
    mode_max = 1'b1;
    bias_perf = 1'b0;
    tick();
    check("R3 maximum mode", int'(req_ratio), 40);
    mode_max = 1'b0;
    bias_perf = 1'b1;
    tick();
    check("R7 direct fall", int'(req_ratio), 8);
  endtask

  task automatic t_lock();
    scale_lock = 1'b1;
    core_halt = '1;
    tick();
    check("R4 lock pins top", int'(req_ratio), 40);
    scale_lock = 1'b0;
    tick();
    check("R4 unlocked scales", int'(req_ratio), 8);
  endtask

  task automatic t_clamp();
    core_halt = '0;
    for (int k = 0; k < NC; k++) set_core(k, 3);
    set_core(5, 50);
    tick();
    check("R10 clamp top", int'(req_ratio), 40);
    set_core(5, 3);
    tick();
    check("R10 clamp floor", int'(req_ratio), 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_dynamic_rise();
    t_exclude_halted();
    t_power_descent();
    t_no_tick();
    t_max_mode();
    t_lock();
    t_clamp();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule